// File: doc/BRIEF.md
# VME Slave Control and Status Register Interface

This block is the bus-facing register front end of a detector readout module. It watches a 24-bit-address, 32-bit-data VME slave bus. It claims an access when three conditions hold: the address modifier is one of the accepted single-cycle codes, the upper address bits match a base address set by four 4-bit switches, and the low byte selects one of four mapped locations. It acknowledges a claimed access with DTACK and returns read data on the same bus.

Behind the bus it keeps the module's static settings. These are a 5-bit clock-delay code, a 3-bit trigger delay, a 2-bit operating mode, two 8-bit header threshold levels and an external-trigger disable. It also reflects live status from the capture logic: busy, timing-receiver ready, trigger count, FIFO full/empty and FIFO word count. Register writes produce a one-cycle software trigger, a one-cycle module reset that clears every setting, and a level-held receiver reset. The FIFO storage sits outside the block and is reached through read and write strobe ports.

VME strobes are asynchronous to the 40 MHz module clock. The block passes them through a two-flop synchroniser and performs exactly one register action per strobe assertion. While the capture logic reports busy, the FIFO location is refused and never acknowledged, so the master times out. The register locations stay fully usable during that time.

Top module: `vme_ctrl_regs`

## Requirements
- R1: An access is claimed only when the address modifier is 0x39, 0x3A, 0x3D or 0x3E. With any other modifier, including the block-transfer codes, there is no DTACK and no register changes.
- R2: The base address for bus bits 23..8 is {sw3, sw2, sw1, sw0}, with sw3 giving bits 23..20 and sw0 giving bits 11..8. An access to any other base is not acknowledged and changes nothing.
- R3: The low address byte maps 0x00 to the configuration register, 0x04 to the status/command register, 0x08 to the reset register and 0x10 to the FIFO port. Any other offset is not acknowledged.
- R4: The configuration register holds the clock-delay code in bits 4:0, trigger delay in 7:5, mode in 9:8, low threshold in 23:16 and high threshold in 31:24. It reads back exactly what was written in those bits. Bits 13:12 read the revision parameter and 15:14 the version parameter, and bits 11:10 read 0.
- R5: A status read returns busy in bit 0, receiver ready in bit 1, external-trigger disable in bit 2, trigger count in 15:4, FIFO full in 16, FIFO empty in 17 and FIFO count in 31:20. All other bits read 0.
- R6: Writing the status/command register with bit 0 set gives a one-clock software trigger pulse. Bit 2 of the same write is stored as the external-trigger disable.
- R7: Writing the reset register with bit 0 set gives a one-clock module reset pulse. That pulse returns every stored setting, the trigger disable and the receiver reset to zero.
- R8: Bit 1 of the reset register drives the receiver reset output. A write of 1 raises it, a later write of 0 drops it, and it reads back in bit 1.
- R9: A FIFO-port read when not busy gives one fifo_rd_o pulse and returns fifo_rdata_i on the bus. A FIFO-port write when not busy gives one fifo_wr_o pulse with the bus write data on fifo_wdata_o.
- R10: While busy_i is high, FIFO-port accesses get no DTACK and no FIFO strobe. Accesses to the other three registers still complete normally.
- R11: DTACK goes low on the third rising clock edge after the strobes assert and goes high on the third rising edge after they release. A strobe held for many cycles performs its action exactly once.
- R12: After rst_n all settings, pulses and read data are zero and DTACK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds_n | input | 1 | Data strobe, active low |
| vme_write_n | input | 1 | Low for write cycles |
| vme_am | input | 6 | Address modifier |
| vme_addr | input | 24 | Bus address |
| vme_wdata | input | 32 | Bus write data |
| vme_rdata | output | 32 | Bus read data, valid while DTACK is low |
| vme_dtack_n | output | 1 | Data acknowledge, active low |
| base_sw3 | input | 4 | Base switch for address bits 23..20 |
| base_sw2 | input | 4 | Base switch for address bits 19..16 |
| base_sw1 | input | 4 | Base switch for address bits 15..12 |
| base_sw0 | input | 4 | Base switch for address bits 11..8 |
| busy_i | input | 1 | Capture logic busy |
| rx_ready_i | input | 1 | Timing receiver ready |
| trig_count_i | input | 12 | Trigger count from capture logic |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_empty_i | input | 1 | FIFO empty flag |
| fifo_count_i | input | 12 | FIFO word count |
| fifo_rdata_i | input | 32 | FIFO head word |
| fifo_rd_o | output | 1 | FIFO read strobe, one clock |
| fifo_wr_o | output | 1 | FIFO write strobe, one clock |
| fifo_wdata_o | output | 32 | FIFO write word |
| sw_trig_o | output | 1 | Software trigger pulse |
| ext_trig_dis_o | output | 1 | External trigger disable |
| mod_reset_o | output | 1 | Module reset pulse |
| rx_reset_o | output | 1 | Timing receiver reset level |
| clk_dly_o | output | 5 | Converter clock-delay code |
| trig_dly_o | output | 3 | External trigger delay |
| mode_o | output | 2 | Operating mode |
| lo_lim_o | output | 8 | Low header threshold |
| hi_lim_o | output | 8 | High header threshold |

## Verification
The assertions assume a well-behaved bus master. Address, modifier, write flag and write data must be stable for the whole time the strobes are low. The strobes must stay released long enough for the synchroniser to see them drop before the next cycle begins. The status inputs from the capture logic are assumed to be synchronous to the module clock. The bench drives every bus signal on the falling clock edge and sets the address fields before lowering the strobes. It keeps the strobes low until DTACK is seen or a timeout passes, then waits for DTACK to release before starting the next cycle. The busy and status inputs change only between bus cycles.

// File: rtl/vmeif_pkg.sv
package vmeif_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 24;
  localparam int OFS_W  = 8;
  localparam int BASE_W = ADDR_W - OFS_W;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_STAT,
    SEL_RST,
    SEL_FIFO
  } sel_e;

  localparam logic [OFS_W-1:0] OFS_CFG  = 8'h00;
  localparam logic [OFS_W-1:0] OFS_STAT = 8'h04;
  localparam logic [OFS_W-1:0] OFS_RST  = 8'h08;
  localparam logic [OFS_W-1:0] OFS_FIFO = 8'h10;

  function automatic logic am_accepted(input logic [5:0] am);
    return (am == 6'h39) || (am == 6'h3A) || (am == 6'h3D) || (am == 6'h3E);
  endfunction
endpackage

// File: rtl/vme_strobe_sync.sv
module vme_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic strobe_lvl,
  output logic strobe_start
);
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-1:0], strobe_async};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign strobe_lvl   = chain_q[STAGES-1];
  assign strobe_start = chain_q[STAGES-1] & ~chain_q[STAGES];

  // one action per strobe assertion
  assert_single_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_start |=> !strobe_start);
endmodule

// File: rtl/vme_addr_match.sv
module vme_addr_match
  import vmeif_pkg::*;
#(
  parameter int NIBBLES = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [5:0]           am,
  input  logic [4*NIBBLES-1:0] base,
  output sel_e                 sel
);
  logic base_hit;
  logic am_hit;

  assign base_hit = (addr[ADDR_W-1:OFS_W] == base);
  assign am_hit   = am_accepted(am);

  always_comb begin
    sel = SEL_NONE;
    if (base_hit && am_hit) begin
      case (addr[OFS_W-1:0])
        OFS_CFG:  sel = SEL_CFG;
        OFS_STAT: sel = SEL_STAT;
        OFS_RST:  sel = SEL_RST;
        OFS_FIFO: sel = SEL_FIFO;
        default:  sel = SEL_NONE;
      endcase
    end
  end

  initial assert (NIBBLES * 4 == BASE_W) else $error("base width mismatch R2");
endmodule

// File: rtl/vme_reg_file.sv
module vme_reg_file
  import vmeif_pkg::*;
#(
  parameter logic [1:0] REVISION = 2'd3,
  parameter logic [1:0] VERSION  = 2'd2,
  parameter int         CNT_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              wr,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy_i,
  input  logic              rx_ready_i,
  input  logic [CNT_W-1:0]  trig_count_i,
  input  logic              fifo_full_i,
  input  logic              fifo_empty_i,
  input  logic [CNT_W-1:0]  fifo_count_i,
  input  logic [DATA_W-1:0] fifo_rdata_i,
  output logic [DATA_W-1:0] rdata,
  output logic              fifo_rd_o,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_wdata_o,
  output logic              sw_trig_o,
  output logic              ext_trig_dis_o,
  output logic              mod_reset_o,
  output logic              rx_reset_o,
  output logic [4:0]        clk_dly_o,
  output logic [2:0]        trig_dly_o,
  output logic [1:0]        mode_o,
  output logic [7:0]        lo_lim_o,
  output logic [7:0]        hi_lim_o
);
  localparam int CFG_W = 26;

  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic              dis_q, dis_d, rxr_q, rxr_d;
  logic              trig_q, trig_d, modrst_q, modrst_d;
  logic              frd_q, frd_d, fwr_q, fwr_d;
  logic [DATA_W-1:0] fwdata_q, fwdata_d, rdata_q, rdata_d;
  logic [DATA_W-1:0] cfg_view, stat_view, rst_view;

  assign cfg_view  = {cfg_q[25:10], VERSION, REVISION, 2'b00, cfg_q[9:0]};
  assign stat_view = {fifo_count_i, 2'b00, fifo_empty_i, fifo_full_i, trig_count_i,
                      1'b0, dis_q, rx_ready_i, busy_i};
  assign rst_view  = {30'b0, rxr_q, 1'b0};

  always_comb begin
    cfg_d    = cfg_q;
    dis_d    = dis_q;
    rxr_d    = rxr_q;
    fwdata_d = fwdata_q;
    rdata_d  = rdata_q;
    trig_d   = 1'b0;
    modrst_d = 1'b0;
    frd_d    = 1'b0;
    fwr_d    = 1'b0;
    if (modrst_q) begin
      cfg_d   = '0;
      dis_d   = 1'b0;
      rxr_d   = 1'b0;
      rdata_d = '0;
    end else if (go) begin
      case (sel)
        SEL_CFG: begin
          if (wr) cfg_d = {wdata[31:16], wdata[9:0]};
          else    rdata_d = cfg_view;
        end
        SEL_STAT: begin
          if (wr) begin
            trig_d = wdata[0];
            dis_d  = wdata[2];
          end else rdata_d = stat_view;
        end
        SEL_RST: begin
          if (wr) begin
            modrst_d = wdata[0];
            rxr_d    = wdata[1];
          end else rdata_d = rst_view;
        end
        SEL_FIFO: begin
          if (wr) begin
            fwr_d    = 1'b1;
            fwdata_d = wdata;
          end else begin
            frd_d   = 1'b1;
            rdata_d = fifo_rdata_i;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      dis_q    <= 1'b0;
      rxr_q    <= 1'b0;
      trig_q   <= 1'b0;
      modrst_q <= 1'b0;
      frd_q    <= 1'b0;
      fwr_q    <= 1'b0;
      fwdata_q <= '0;
      rdata_q  <= '0;
    end else begin
      cfg_q    <= cfg_d;
      dis_q    <= dis_d;
      rxr_q    <= rxr_d;
      trig_q   <= trig_d;
      modrst_q <= modrst_d;
      frd_q    <= frd_d;
      fwr_q    <= fwr_d;
      fwdata_q <= fwdata_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rdata          = rdata_q;
  assign fifo_rd_o      = frd_q;
  assign fifo_wr_o      = fwr_q;
  assign fifo_wdata_o   = fwdata_q;
  assign sw_trig_o      = trig_q;
  assign ext_trig_dis_o = dis_q;
  assign mod_reset_o    = modrst_q;
  assign rx_reset_o     = rxr_q;
  assign clk_dly_o      = cfg_q[4:0];
  assign trig_dly_o     = cfg_q[7:5];
  assign mode_o         = cfg_q[9:8];
  assign lo_lim_o       = cfg_q[17:10];
  assign hi_lim_o       = cfg_q[25:18];

  assert_fifo_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd_o || fifo_wr_o) |-> $past(!busy_i));
  assert_fifo_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_rd_o, fifo_wr_o}));
  assert_reset_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mod_reset_o |=> (clk_dly_o == '0 && mode_o == '0 && hi_lim_o == '0 &&
                     !ext_trig_dis_o && !rx_reset_o));
  assert_trig_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trig_o |=> !sw_trig_o);
endmodule

// File: rtl/vme_ctrl_regs.sv
module vme_ctrl_regs
  import vmeif_pkg::*;
#(
  parameter logic [1:0] REVISION    = 2'd3,
  parameter logic [1:0] VERSION     = 2'd2,
  parameter int         SYNC_STAGES = 2,
  parameter int         CNT_W       = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vme_as_n,
  input  logic              vme_ds_n,
  input  logic              vme_write_n,
  input  logic [5:0]        vme_am,
  input  logic [23:0]       vme_addr,
  input  logic [31:0]       vme_wdata,
  output logic [31:0]       vme_rdata,
  output logic              vme_dtack_n,
  input  logic [3:0]        base_sw3,
  input  logic [3:0]        base_sw2,
  input  logic [3:0]        base_sw1,
  input  logic [3:0]        base_sw0,
  input  logic              busy_i,
  input  logic              rx_ready_i,
  input  logic [CNT_W-1:0]  trig_count_i,
  input  logic              fifo_full_i,
  input  logic              fifo_empty_i,
  input  logic [CNT_W-1:0]  fifo_count_i,
  input  logic [31:0]       fifo_rdata_i,
  output logic              fifo_rd_o,
  output logic              fifo_wr_o,
  output logic [31:0]       fifo_wdata_o,
  output logic              sw_trig_o,
  output logic              ext_trig_dis_o,
  output logic              mod_reset_o,
  output logic              rx_reset_o,
  output logic [4:0]        clk_dly_o,
  output logic [2:0]        trig_dly_o,
  output logic [1:0]        mode_o,
  output logic [7:0]        lo_lim_o,
  output logic [7:0]        hi_lim_o
);
  logic strobe_lvl, strobe_start, go;
  logic ack_q, ack_d;
  sel_e sel;

  vme_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_async (~vme_as_n & ~vme_ds_n),
    .strobe_lvl   (strobe_lvl),
    .strobe_start (strobe_start)
  );

  vme_addr_match #(.NIBBLES(4)) u_match (
    .addr (vme_addr),
    .am   (vme_am),
    .base ({base_sw3, base_sw2, base_sw1, base_sw0}),
    .sel  (sel)
  );

  assign go = strobe_start && (sel != SEL_NONE) && !((sel == SEL_FIFO) && busy_i);

  always_comb begin
    if (ack_q) ack_d = strobe_lvl;
    else       ack_d = go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign vme_dtack_n = ~ack_q;

  vme_reg_file #(.REVISION(REVISION), .VERSION(VERSION), .CNT_W(CNT_W)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .go             (go),
    .wr             (~vme_write_n),
    .sel            (sel),
    .wdata          (vme_wdata),
    .busy_i         (busy_i),
    .rx_ready_i     (rx_ready_i),
    .trig_count_i   (trig_count_i),
    .fifo_full_i    (fifo_full_i),
    .fifo_empty_i   (fifo_empty_i),
    .fifo_count_i   (fifo_count_i),
    .fifo_rdata_i   (fifo_rdata_i),
    .rdata          (vme_rdata),
    .fifo_rd_o      (fifo_rd_o),
    .fifo_wr_o      (fifo_wr_o),
    .fifo_wdata_o   (fifo_wdata_o),
    .sw_trig_o      (sw_trig_o),
    .ext_trig_dis_o (ext_trig_dis_o),
    .mod_reset_o    (mod_reset_o),
    .rx_reset_o     (rx_reset_o),
    .clk_dly_o      (clk_dly_o),
    .trig_dly_o     (trig_dly_o),
    .mode_o         (mode_o),
    .lo_lim_o       (lo_lim_o),
    .hi_lim_o       (hi_lim_o)
  );

  assert_ack_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !vme_dtack_n |-> (strobe_lvl || $past(strobe_lvl)));
  assert_ack_rises_on_go_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vme_dtack_n) |-> $past(strobe_start));
  assert_strobe_needs_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd_o || fifo_wr_o || sw_trig_o || mod_reset_o) |-> !vme_dtack_n);
endmodule

// File: tb/sim_vme_ctrl_regs.sv
module sim_vme_ctrl_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_n = 1'b1, ds_n = 1'b1, write_n = 1'b1;
  logic [5:0]  am = '0;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic dtack_n;
  logic busy = 1'b0, rx_ready = 1'b1, full = 1'b0, empty = 1'b1;
  logic [11:0] tcnt = 12'h5A3, fcnt = 12'h07E;
  logic [31:0] fifo_rd_word = 32'hCAFE_0042;
  logic fifo_rd, fifo_wr, sw_trig, ext_dis, mod_rst, rx_rst;
  logic [31:0] fifo_wword;
  logic [4:0] clk_dly;
  logic [2:0] trig_dly;
  logic [1:0] mode;
  logic [7:0] lo_lim, hi_lim;

  int checks = 0;
  int errors = 0;
  int n_trig = 0, n_rd = 0, n_wr = 0, n_mrst = 0;
  logic [31:0] last_wword = '0;

  always #4 clk = ~clk;

  vme_ctrl_regs u0 (
    .clk(clk), .rst_n(rst_n), .vme_as_n(as_n), .vme_ds_n(ds_n), .vme_write_n(write_n),
    .vme_am(am), .vme_addr(addr), .vme_wdata(wdata), .vme_rdata(rdata), .vme_dtack_n(dtack_n),
    .base_sw3(4'hA), .base_sw2(4'h5), .base_sw1(4'h3), .base_sw0(4'hC),
    .busy_i(busy), .rx_ready_i(rx_ready), .trig_count_i(tcnt), .fifo_full_i(full),
    .fifo_empty_i(empty), .fifo_count_i(fcnt), .fifo_rdata_i(fifo_rd_word),
    .fifo_rd_o(fifo_rd), .fifo_wr_o(fifo_wr), .fifo_wdata_o(fifo_wword), .sw_trig_o(sw_trig),
    .ext_trig_dis_o(ext_dis), .mod_reset_o(mod_rst), .rx_reset_o(rx_rst),
    .clk_dly_o(clk_dly), .trig_dly_o(trig_dly), .mode_o(mode), .lo_lim_o(lo_lim), .hi_lim_o(hi_lim)
  );

  always @(negedge clk) begin
    if (sw_trig) n_trig++;
    if (fifo_rd) n_rd++;
    if (fifo_wr) begin n_wr++; last_wword = fifo_wword; end
    if (mod_rst) n_mrst++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [5:0] m, input logic [23:0] a,
                        input logic [31:0] d, input int hold,
                        output bit acked, output logic [31:0] rd, output int lat);
    @(negedge clk);
    write_n = ~wr; am = m; addr = a; wdata = d;
    as_n = 1'b0; ds_n = 1'b0;
    acked = 1'b0; lat = 0; rd = '0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (!dtack_n) begin acked = 1'b1; lat = i; rd = rdata; break; end
    end
    repeat (hold) @(negedge clk);
    as_n = 1'b1; ds_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (dtack_n && i >= 3) break;
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [5:0]  am;
    logic [23:0] addr;
    logic [31:0] data;
    logic        ack;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 6'h39, 24'hA53C00, 32'h5AC302A7, 1'b1},  // R4 write config
    '{1'b0, 6'h3A, 24'hA53C00, 32'h5AC3B2A7, 1'b1},  // R1 R4 read back
    '{1'b0, 6'h3D, 24'hA53C00, 32'h5AC3B2A7, 1'b1},  // R1
    '{1'b0, 6'h3E, 24'hA53C00, 32'h5AC3B2A7, 1'b1},  // R1
    '{1'b0, 6'h09, 24'hA53C00, 32'h0,        1'b0},  // R1 refused modifier
    '{1'b0, 6'h3B, 24'hA53C00, 32'h0,        1'b0},  // R1 block code refused
    '{1'b0, 6'h39, 24'hA53C04, 32'h07E25A32, 1'b1},  // R5 status
    '{1'b0, 6'h39, 24'hA53C0C, 32'h0,        1'b0},  // R3 unmapped
    '{1'b0, 6'h39, 24'hA53C14, 32'h0,        1'b0},  // R3 unmapped
    '{1'b1, 6'h39, 24'hA53C04, 32'h00000004, 1'b1},  // R6 disable
    '{1'b0, 6'h39, 24'hA53C04, 32'h07E25A36, 1'b1},  // R6 R5
    '{1'b0, 6'h39, 24'hA53C08, 32'h00000000, 1'b1},  // R3 reset reg
    '{1'b1, 6'h09, 24'hA53C00, 32'h0,        1'b0},  // R1 ignored write
    '{1'b0, 6'h39, 24'hA53C00, 32'h5AC3B2A7, 1'b1},  // R1 unchanged
    '{1'b1, 6'h39, 24'hA53D00, 32'h0,        1'b0},  // R2 other base
    '{1'b0, 6'h39, 24'hA53C00, 32'h5AC3B2A7, 1'b1}   // R2 unchanged
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    logic [31:0] rd;
    int lat, base_cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(dtack_n === 1'b1, "R12 dtack", {31'b0, dtack_n}, 32'd1);
    check({clk_dly, trig_dly, mode, lo_lim, hi_lim, ext_dis, rx_rst, sw_trig} === '0,
          "R12 settings", {8'b0, clk_dly, trig_dly, mode, lo_lim, hi_lim}, 32'd0);
    check(rdata === '0, "R12 rdata", rdata, 32'd0);
    access(1'b0, 6'h39, 24'hA53C00, 0, 0, ack, rd, lat);
    check(ack && rd === 32'h0000B000, "R12 R4 cfg after reset", rd, 32'h0000B000);
    check(lat == 3, "R11 ack latency", lat, 32'd3);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].am, VEC[i].addr, VEC[i].data, 0, ack, rd, lat);
      check(ack == VEC[i].ack, $sformatf("R1 R2 R3 vec%0d ack", i), {31'b0, ack}, {31'b0, VEC[i].ack});
      if (VEC[i].ack && !VEC[i].wr)
        check(rd === VEC[i].data, $sformatf("R4 R5 vec%0d data", i), rd, VEC[i].data);
    end
    check(clk_dly == 5'h07 && trig_dly == 3'd5 && mode == 2'd2 && lo_lim == 8'hC3 && hi_lim == 8'h5A,
          "R4 outputs", {8'b0, hi_lim, lo_lim, 1'b0, trig_dly, 1'b0, mode, clk_dly[3:0]}, 32'h5AC35027);
    check(ext_dis === 1'b1, "R6 disable out", {31'b0, ext_dis}, 32'd1);

    // R6 R11 held strobe gives one trigger
    base_cnt = n_trig;
    access(1'b1, 6'h39, 24'hA53C04, 32'h1, 6, ack, rd, lat);
    check(ack && (n_trig - base_cnt) == 1, "R6 R11 single trigger", n_trig - base_cnt, 32'd1);

    // R9 FIFO read and write
    base_cnt = n_rd;
    access(1'b0, 6'h39, 24'hA53C10, 0, 0, ack, rd, lat);
    check(ack && rd === 32'hCAFE0042 && (n_rd - base_cnt) == 1, "R9 fifo read", rd, 32'hCAFE0042);
    base_cnt = n_wr;
    access(1'b1, 6'h3E, 24'hA53C10, 32'h1234ABCD, 0, ack, rd, lat);
    check(ack && (n_wr - base_cnt) == 1 && last_wword === 32'h1234ABCD, "R9 fifo write",
          last_wword, 32'h1234ABCD);

    // R10 busy blocks FIFO only
    busy = 1'b1;
    base_cnt = n_rd;
    access(1'b0, 6'h39, 24'hA53C10, 0, 0, ack, rd, lat);
    check(!ack && n_rd == base_cnt, "R10 busy fifo read refused", {31'b0, ack}, 32'd0);
    base_cnt = n_wr;
    access(1'b1, 6'h39, 24'hA53C10, 32'hFFFF, 0, ack, rd, lat);
    check(!ack && n_wr == base_cnt, "R10 busy fifo write refused", n_wr - base_cnt, 32'd0);
    access(1'b1, 6'h39, 24'hA53C00, 32'hFFFFFFFF, 0, ack, rd, lat);
    access(1'b0, 6'h39, 24'hA53C00, 0, 0, ack, rd, lat);
    check(ack && rd === 32'hFFFFB3FF, "R10 R4 cfg while busy", rd, 32'hFFFFB3FF);
    access(1'b0, 6'h39, 24'hA53C04, 0, 0, ack, rd, lat);
    check(ack && rd === 32'h07E25A33, "R10 R5 busy bit", rd, 32'h07E25A33);
    busy = 1'b0;

    // R8 receiver reset level
    access(1'b1, 6'h39, 24'hA53C08, 32'h2, 0, ack, rd, lat);
    check(rx_rst === 1'b1, "R8 rx reset high", {31'b0, rx_rst}, 32'd1);
    access(1'b0, 6'h39, 24'hA53C08, 0, 0, ack, rd, lat);
    check(rd === 32'h2, "R8 readback", rd, 32'h2);
    access(1'b1, 6'h39, 24'hA53C08, 32'h0, 0, ack, rd, lat);
    check(rx_rst === 1'b0, "R8 rx reset low", {31'b0, rx_rst}, 32'd0);

    // R7 module reset clears settings
    access(1'b1, 6'h39, 24'hA53C08, 32'h2, 0, ack, rd, lat);
    access(1'b1, 6'h39, 24'hA53C04, 32'h4, 0, ack, rd, lat);
    base_cnt = n_mrst;
    access(1'b1, 6'h39, 24'hA53C08, 32'h1, 0, ack, rd, lat);
    check(ack && (n_mrst - base_cnt) == 1, "R7 reset pulse", n_mrst - base_cnt, 32'd1);
    check(!rx_rst && !ext_dis && clk_dly == 0 && hi_lim == 0, "R7 outputs cleared",
          {24'b0, hi_lim}, 32'd0);
    access(1'b0, 6'h39, 24'hA53C00, 0, 0, ack, rd, lat);
    check(rd === 32'h0000B000, "R7 cfg cleared", rd, 32'h0000B000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule